// File: doc/BRIEF.md
# CAN Transmit Fault-Confinement Tracker

This block follows one CAN node's transmit error count and decides which fault-confinement state the node is in: error-active, error-passive or bus-off. Each transmit error reported by the protocol engine raises the count by eight. Each frame sent without error lowers it by one. When the count goes past the passive limit, the node becomes error-passive. When it goes past the bus-off limit, the node is taken off the bus. While the node is isolated, the path into its receive unit is held recessive.

Two limit sets are available, chosen by a configuration input. The standard set uses a passive limit of 127 and a bus-off limit of 255. The tightened set uses 63 and 127. A node in bus-off watches sampled bus bits and counts runs of eleven recessive bits in a row. After 128 runs (standard set) or 64 runs (tightened set), it rejoins the bus as error-active with a cleared count. Two cycle counters report how long an attack takes to isolate the node (detection time) and how long the node stays isolated (response time).

Top module: `can_fault_confine`

## Requirements
- R1: While rst_n is low and right after it is released, err_state is 0, tec is 0, isolated is 0, and both detect_cycles and response_cycles are 0.
- R2: Outside bus-off, a cycle with tx_err high adds 8 to tec. A cycle with only tx_ok high subtracts 1 from tec. A tx_ok when tec is 0 leaves tec at 0.
- R3: The state code is 1 (error-passive) while tec is above the passive limit and no more than the bus-off limit. The state code is 0 (error-active) while tec is at or below the passive limit. The passive limit is 127 when the configuration is 0 and 63 when it is 1.
- R4: When tec goes above the bus-off limit (255 for configuration 0, 127 for configuration 1), err_state becomes 2 (bus-off) and isolated becomes 1 in the same cycle.
- R5: In bus-off, tx_err and tx_ok have no effect. tec keeps the value it had on entry.
- R6: In bus-off, each cycle with bit_tick high samples bus_bit, where 1 means recessive. Eleven recessive samples in a row complete one run, and a dominant sample restarts the current run from zero. The node leaves bus-off on the cycle that completes run 128 (configuration 0) or run 64 (configuration 1).
- R7: On leaving bus-off, err_state returns to 0 and tec is cleared to 0.
- R8: rx_to_unit is 1 while isolated is 1. Otherwise rx_to_unit equals rx_in.
- R9: cfg_sel is taken into the active configuration only in a cycle where the node is error-active with tec equal to 0. Changes to cfg_sel at any other time have no effect on the limits.
- R10: detect_cycles reports the number of clock cycles from the first counted transmit error through the cycle of bus-off entry, inclusive. response_cycles reports the number of cycles the node spent in bus-off. Each value holds until the next measurement completes. A detection measurement is abandoned if tec returns to 0 first.
- R11: If tx_err and tx_ok are high in the same cycle, the error wins: tec rises by 8 and the success is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Limit set request: 0 = 127/255 with 128 runs, 1 = 63/127 with 64 runs |
| tx_err | input | 1 | One-cycle pulse: a transmit error was detected |
| tx_ok | input | 1 | One-cycle pulse: a frame was sent without error |
| bit_tick | input | 1 | Marks a cycle in which bus_bit holds a sampled bus bit |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| rx_in | input | 1 | Receive line from the transceiver side |
| err_state | output | 2 | 0 error-active, 1 error-passive, 2 bus-off |
| tec | output | 9 | Transmit error count |
| isolated | output | 1 | Node is cut off from the bus |
| rx_to_unit | output | 1 | Receive line passed to the receive unit |
| detect_cycles | output | 16 | Last measured cycles from first error to bus-off |
| response_cycles | output | 16 | Last measured cycles spent in bus-off |

## Verification
Two pieces of logic can claim the same cycle: the error increment and the success decrement. The bench drives tx_err and tx_ok high together while tec is zero and expects tec to read 8 afterwards, which shows that the error path won and the success was dropped rather than netted against it.

A second overlap is a configuration change that arrives while the count is non-zero. The bench raises cfg_sel partway through an error burst and judges the result at the ports: the state must stay error-active at a count that only the tightened limits would call passive.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

    typedef struct packed {
        fc_state_e state;
        logic      cfg_b;
    } fc_ctrl_t;
endpackage

// File: rtl/can_fc_tec.sv
module can_fc_tec #(
    parameter int W    = 9,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         clr,
    input  logic         freeze,
    output logic [W-1:0] tec_next,
    output logic [W-1:0] tec
);
    localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

    typedef struct packed {
        logic [W-1:0] val;
    } tec_t;

    tec_t       st_d, st_q;
    logic [W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.val} + (W+1)'(STEP);
        if (clr) begin
            st_d.val = '0;
        end else if (!freeze) begin
            if (inc) begin
                st_d.val = (sum > MAXV) ? MAXV[W-1:0] : sum[W-1:0];
            end else if (dec && st_q.val != '0) begin
                st_d.val = st_q.val - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tec_next = st_d.val;
    assign tec      = st_q.val;

    // R2: never wraps below zero
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && !clr && !freeze && st_q.val == '0) |=> st_q.val == '0);

    // R2: an error step adds STEP when room remains
    p_err_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !freeze && {1'b0, st_q.val} <= MAXV - (W+1)'(STEP))
        |=> st_q.val == $past(st_q.val) + W'(STEP));
endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
    parameter int RUN_LEN = 11,
    parameter int RUNS_A  = 128,
    parameter int RUNS_B  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cfg_b,
    input  logic bit_tick,
    input  logic bus_bit,
    output logic done
);
    localparam int RUN_MAX = (RUNS_A > RUNS_B) ? RUNS_A : RUNS_B;
    localparam int BIT_W   = $clog2(RUN_LEN);
    localparam int RUN_W   = $clog2(RUN_MAX + 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(RUN_LEN - 1);

    typedef struct packed {
        logic [BIT_W-1:0] bits;
        logic [RUN_W-1:0] runs;
    } rec_t;

    rec_t             st_d, st_q;
    logic [RUN_W-1:0] run_last;
    logic             run_end;

    always_comb begin
        run_last = cfg_b ? RUN_W'(RUNS_B - 1) : RUN_W'(RUNS_A - 1);
        run_end  = enable && bit_tick && bus_bit && (st_q.bits == BIT_LAST);
        done     = run_end && (st_q.runs == run_last);
        st_d     = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (bit_tick) begin
            if (!bus_bit) begin
                st_d.bits = '0;
            end else if (run_end) begin
                st_d.bits = '0;
                st_d.runs = done ? '0 : st_q.runs + 1'b1;
            end else begin
                st_d.bits = st_q.bits + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the bit position never exceeds one run
    p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bits <= BIT_LAST);

    // R6: a dominant sample restarts the current run
    p_dominant_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && bit_tick && !bus_bit) |=> st_q.bits == '0);
endmodule

// File: rtl/can_fc_timer.sv
module can_fc_timer #(
    parameter int W    = 16,
    parameter int INIT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         stop,
    input  logic         abort,
    output logic [W-1:0] result
);
    typedef struct packed {
        logic         busy;
        logic [W-1:0] cnt;
        logic [W-1:0] res;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
            if (stop) begin
                st_d.res  = st_d.cnt;
                st_d.busy = 1'b0;
            end else if (abort) begin
                st_d.busy = 1'b0;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = W'(INIT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.res;

    // R10: a reported value holds until a measurement completes
    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stop |=> $stable(st_q.res));
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine #(
    parameter int TEC_W    = 9,
    parameter int ERR_STEP = 8,
    parameter int PAS_A    = 127,
    parameter int BO_A     = 255,
    parameter int PAS_B    = 63,
    parameter int BO_B     = 127,
    parameter int RUN_LEN  = 11,
    parameter int RUNS_A   = 128,
    parameter int RUNS_B   = 64,
    parameter int TIME_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              tx_err,
    input  logic              tx_ok,
    input  logic              bit_tick,
    input  logic              bus_bit,
    input  logic              rx_in,
    output logic [1:0]        err_state,
    output logic [TEC_W-1:0]  tec,
    output logic              isolated,
    output logic              rx_to_unit,
    output logic [TIME_W-1:0] detect_cycles,
    output logic [TIME_W-1:0] response_cycles
);
    import can_fc_pkg::*;

    fc_ctrl_t         ctrl_d, ctrl_q;
    logic [TEC_W-1:0] tec_q, tec_next;
    logic [TEC_W-1:0] pas_th, bo_th;
    logic             in_busoff, inc, dec, rec_done, entering;

    always_comb begin
        pas_th = ctrl_q.cfg_b ? TEC_W'(PAS_B) : TEC_W'(PAS_A);
        bo_th  = ctrl_q.cfg_b ? TEC_W'(BO_B)  : TEC_W'(BO_A);
    end

    assign in_busoff = (ctrl_q.state == FC_BUSOFF);
    assign inc       = tx_err && !in_busoff;
    assign dec       = tx_ok && !tx_err && !in_busoff;

    can_fc_tec #(.W(TEC_W), .STEP(ERR_STEP)) u_tec (
        .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec), .clr(rec_done),
        .freeze(in_busoff), .tec_next(tec_next), .tec(tec_q)
    );

    can_fc_recovery #(.RUN_LEN(RUN_LEN), .RUNS_A(RUNS_A), .RUNS_B(RUNS_B)) u_rec (
        .clk(clk), .rst_n(rst_n), .enable(in_busoff), .cfg_b(ctrl_q.cfg_b),
        .bit_tick(bit_tick), .bus_bit(bus_bit), .done(rec_done)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_q.state == FC_ACTIVE && tec_q == '0) ctrl_d.cfg_b = cfg_sel;
        if (in_busoff) begin
            if (rec_done) ctrl_d.state = FC_ACTIVE;
        end else if (tec_next > bo_th) begin
            ctrl_d.state = FC_BUSOFF;
        end else if (tec_next > pas_th) begin
            ctrl_d.state = FC_PASSIVE;
        end else begin
            ctrl_d.state = FC_ACTIVE;
        end
        entering = !in_busoff && (ctrl_d.state == FC_BUSOFF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '{state: FC_ACTIVE, cfg_b: 1'b0};
        else        ctrl_q <= ctrl_d;
    end

    can_fc_timer #(.W(TIME_W), .INIT(1)) u_detect (
        .clk(clk), .rst_n(rst_n), .start(inc), .stop(entering),
        .abort(tec_next == '0), .result(detect_cycles)
    );

    can_fc_timer #(.W(TIME_W), .INIT(0)) u_response (
        .clk(clk), .rst_n(rst_n), .start(entering), .stop(rec_done),
        .abort(1'b0), .result(response_cycles)
    );

    assign err_state  = ctrl_q.state;
    assign tec        = tec_q;
    assign isolated   = in_busoff;
    assign rx_to_unit = in_busoff | rx_in;

    // R4: isolation only follows a count past the bus-off limit
    p_busoff_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isolated) |-> tec > bo_th);

    // R7: leaving bus-off lands in error-active with a clear count
    p_exit_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(isolated) |-> (tec == '0 && err_state == 2'd0));

    // R5: the count is frozen while isolated, apart from the exit clear
    p_busoff_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        isolated |=> (tec == $past(tec) || tec == '0));

    // R9: the limit set cannot change while the count is non-zero
    p_cfg_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tec_q != '0) |=> $stable(ctrl_q.cfg_b));

    // R3: the passive code only appears inside the passive band
    p_passive_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_state == 2'd1) |-> (tec > pas_th && tec <= bo_th));
endmodule

// File: tb/can_fault_confine_tb_top.sv
module can_fault_confine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0, tx_err = 1'b0, tx_ok = 1'b0;
    logic        bit_tick = 1'b0, bus_bit = 1'b1, rx_in = 1'b1;
    logic [1:0]  err_state;
    logic [8:0]  tec;
    logic        isolated, rx_to_unit;
    logic [15:0] detect_cycles, response_cycles;
    int          total = 0, bad = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    can_fault_confine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .tx_err(tx_err), .tx_ok(tx_ok),
        .bit_tick(bit_tick), .bus_bit(bus_bit), .rx_in(rx_in),
        .err_state(err_state), .tec(tec), .isolated(isolated), .rx_to_unit(rx_to_unit),
        .detect_cycles(detect_cycles), .response_cycles(response_cycles)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int n, input logic e, input logic o,
                         input logic tk, input logic b);
        repeat (n) begin
            tx_err = e; tx_ok = o; bit_tick = tk; bus_bit = b;
            @(negedge clk);
        end
        tx_err = 1'b0; tx_ok = 1'b0; bit_tick = 1'b0; bus_bit = 1'b1;
    endtask

    task automatic test_reset;
        chk("R1 state", err_state, 0);
        chk("R1 tec", tec, 0);
        chk("R1 isolated", isolated, 0);
        chk("R1 detect", detect_cycles, 0);
        chk("R1 response", response_cycles, 0);
    endtask

    task automatic test_counting;
        cfg_sel = 1'b0;
        drive(2, 1, 0, 0, 1);  chk("R2 add", tec, 16);
        drive(3, 0, 1, 0, 1);  chk("R2 sub", tec, 13);
        drive(13, 0, 1, 0, 1); chk("R2 to zero", tec, 0);
        drive(2, 0, 1, 0, 1);  chk("R2 floor", tec, 0);
        drive(1, 1, 1, 0, 1);  chk("R11 error wins", tec, 8);
        drive(8, 0, 1, 0, 1);  chk("R11 cleanup", tec, 0);
    endtask

    task automatic test_cfg_lock;
        cfg_sel = 1'b0;
        drive(1, 1, 0, 0, 1);
        cfg_sel = 1'b1;
        drive(7, 1, 0, 0, 1);
        chk("R9 tec", tec, 64);
        chk("R9 change ignored", err_state, 0);
        drive(1, 1, 0, 0, 1);  chk("R9 still active", err_state, 0);
        drive(72, 0, 1, 0, 1); chk("R9 drained", tec, 0);
        drive(1, 0, 0, 0, 1);
        drive(8, 1, 0, 0, 1);  chk("R3 passive cfg1", err_state, 1);
        drive(1, 0, 1, 0, 1);  chk("R3 back active cfg1", err_state, 0);
        drive(63, 0, 1, 0, 1); chk("R3 drained", tec, 0);
        cfg_sel = 1'b0;
        drive(1, 0, 0, 0, 1);
    endtask

    task automatic test_cfg_a;
        drive(15, 1, 0, 0, 1);
        chk("R3 below limit", err_state, 0);
        drive(1, 1, 0, 0, 1);
        chk("R3 passive", err_state, 1);
        chk("R2 tec128", tec, 128);
        drive(15, 1, 0, 0, 1);
        chk("R4 not yet", err_state, 1);
        drive(1, 1, 0, 0, 1);
        chk("R4 busoff", err_state, 2);
        chk("R4 isolated", isolated, 1);
        chk("R4 tec", tec, 256);
        chk("R10 detect cfg0", detect_cycles, 32);
        rx_in = 1'b0; #1;
        chk("R8 forced recessive", rx_to_unit, 1);
        @(negedge clk);
        drive(3, 1, 0, 0, 1);
        drive(3, 0, 1, 0, 1);
        chk("R5 tec held", tec, 256);
        chk("R5 still off", err_state, 2);
        drive(1407, 0, 0, 1, 1);
        chk("R6 one short", isolated, 1);
        drive(1, 0, 0, 1, 1);
        chk("R6 recovered", isolated, 0);
        chk("R7 state", err_state, 0);
        chk("R7 tec", tec, 0);
        chk("R10 response cfg0", response_cycles, 1415);
        chk("R8 pass-through", rx_to_unit, 0);
        rx_in = 1'b1;
    endtask

    task automatic test_cfg_b;
        cfg_sel = 1'b1;
        drive(1, 0, 0, 0, 1);
        drive(8, 1, 0, 0, 1);
        chk("R3 passive cfg1", err_state, 1);
        drive(8, 1, 0, 0, 1);
        chk("R4 busoff cfg1", err_state, 2);
        chk("R4 tec cfg1", tec, 128);
        chk("R10 detect cfg1", detect_cycles, 16);
        drive(10, 0, 0, 1, 1);
        drive(1, 0, 0, 1, 0);
        drive(703, 0, 0, 1, 1);
        chk("R6 restart", isolated, 1);
        drive(1, 0, 0, 1, 1);
        chk("R6 recovered cfg1", isolated, 0);
        chk("R7 tec cfg1", tec, 0);
        chk("R10 response cfg1", response_cycles, 715);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_counting;
        test_cfg_lock;
        test_cfg_a;
        test_cfg_b;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule